// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block inspects one data-cache tag entry as it is handed over on a valid/ready stream. It pulls the 5-bit coherence state out of the upper tag word and matches it against the fixed set of legal encodings. A legal state enables the two physical-tag parity checks on the lower tag word. An illegal state raises its own error and skips the parity checks. From the same entry the block also forms the physical line address and unpacks the replacement-order field. Reading the cache array and stepping through the ways is left to the caller.

Each accepted entry gives exactly one result one clock later, held in a single output register. The input is accepted whenever that register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the result stays frozen and `in_ready` drops, so back-pressure reaches the producer with no extra cycle of delay. No entry is lost and none is duplicated.

Top module: `dctag_check`

## Requirements
- R1: The state is `in_tag_hi[29:25]`. `out_state` decodes it as follows: 0x00 gives 0 (invalid), 0x0F gives 1 (coherent shared), 0x13 gives 2 (non-coherent exclusive clean), 0x19 gives 3 (non-coherent exclusive dirty), 0x16 gives 4 (coherent exclusive clean) and 0x1C gives 5 (coherent exclusive dirty).
- R2: Any other state value gives `out_state` = 7 and `out_state_err` = 1. In that case `out_addr_err` = 0 whatever the parity bits hold.
- R3: For a legal state, `out_addr_err` is 1 when `in_tag_lo[11]` differs from the XOR of `in_tag_lo[39:26]`.
- R4: For a legal state, `out_addr_err` is 1 when `in_tag_lo[10]` differs from the XOR of `in_tag_lo[25:13]`. When both parity bits match, `out_addr_err` is 0 and `out_state_err` is 0.
- R5: `out_paddr` is 40 bits: `in_tag_lo[39:13]` in bits 39:13 and `in_index` in bits 12:0.
- R6: `out_lru` equals `in_tag_hi[21:14]`. Bits [2k+1:2k] hold the k-th way number, with k = 0 the least recently used and k = 3 the most recently used.
- R7: An entry accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge. Its outputs stay unchanged while `out_valid` is high and `out_ready` is low.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. Reset clears `out_valid`.
- R9: Bits of `in_tag_lo` outside 39:10 and bits of `in_tag_hi` outside 29:25 and 21:14 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Tag entry present |
| in_ready | output | 1 | Entry can be taken this cycle |
| in_tag_hi | input | 32 | Upper tag word (state, replacement order) |
| in_tag_lo | input | 64 | Lower tag word (physical tag, parity bits) |
| in_index | input | 13 | Set index of the entry |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_state_err | output | 1 | State encoding is not legal |
| out_addr_err | output | 1 | Physical-tag parity mismatch |
| out_state | output | 3 | Decoded state code |
| out_paddr | output | 40 | Physical line address |
| out_lru | output | 8 | Four 2-bit way numbers, least to most recent |

## Verification
The assertions assume that `in_valid` is not dropped while an entry waits for `in_ready`. They also assume `out_ready` is a free-running consumer signal that may take any value on any cycle. The stimulus keeps to this: the driver holds each entry until it sees it accepted, and the consumer side toggles `out_ready` from a pseudo-random pattern. The stimulus covers every legal encoding, illegal encodings that carry both good and corrupted parity, each parity bit corrupted alone and both together, and noise placed in the bits that must be ignored.

// File: rtl/dctag_pkg.sv
package dctag_pkg;

  localparam int STATE_W = 5;
  localparam int CODE_W  = 3;

  localparam logic [STATE_W-1:0] ENC_INVALID   = 5'h00;
  localparam logic [STATE_W-1:0] ENC_SHARED    = 5'h0F;
  localparam logic [STATE_W-1:0] ENC_NCEX_CLN  = 5'h13;
  localparam logic [STATE_W-1:0] ENC_NCEX_DTY  = 5'h19;
  localparam logic [STATE_W-1:0] ENC_CEX_CLN   = 5'h16;
  localparam logic [STATE_W-1:0] ENC_CEX_DTY   = 5'h1C;

  typedef enum logic [CODE_W-1:0] {
    CS_INVALID  = 3'd0,
    CS_SHARED   = 3'd1,
    CS_NCEX_CLN = 3'd2,
    CS_NCEX_DTY = 3'd3,
    CS_CEX_CLN  = 3'd4,
    CS_CEX_DTY  = 3'd5,
    CS_ILLEGAL  = 3'd7
  } cstate_e;

endpackage

// File: rtl/dctag_state_decode.sv
module dctag_state_decode
  import dctag_pkg::*;
(
  input  logic [STATE_W-1:0] raw,
  output cstate_e            code,
  output logic               legal
);

  always_comb begin
    unique case (raw)
      ENC_INVALID:  code = CS_INVALID;
      ENC_SHARED:   code = CS_SHARED;
      ENC_NCEX_CLN: code = CS_NCEX_CLN;
      ENC_NCEX_DTY: code = CS_NCEX_DTY;
      ENC_CEX_CLN:  code = CS_CEX_CLN;
      ENC_CEX_DTY:  code = CS_CEX_DTY;
      default:      code = CS_ILLEGAL;
    endcase
    legal = (code != CS_ILLEGAL);
  end

endmodule

// File: rtl/dctag_span_parity.sv
module dctag_span_parity #(
  parameter int W   = 64,
  parameter int MSB = 39,
  parameter int LSB = 26
) (
  input  logic [W-1:0] word,
  input  logic         stored,
  output logic         mismatch
);

  always_comb begin
    mismatch = stored;
    for (int i = LSB; i <= MSB; i++) begin
      mismatch = mismatch ^ word[i];
    end
  end

endmodule

// File: rtl/dctag_lru_unpack.sv
module dctag_lru_unpack #(
  parameter int WAYS = 4,
  parameter int WW   = 2
) (
  input  logic [WAYS*WW-1:0] field,
  output logic [WAYS*WW-1:0] order
);

  for (genvar k = 0; k < WAYS; k++) begin : g_way
    assign order[k*WW +: WW] = field[k*WW +: WW];
  end

endmodule

// File: rtl/dctag_check.sv
module dctag_check
  import dctag_pkg::*;
#(
  parameter int HI_W      = 32,
  parameter int LO_W      = 64,
  parameter int IDX_W     = 13,
  parameter int PA_W      = 40,
  parameter int STATE_LSB = 25,
  parameter int LRU_LSB   = 14,
  parameter int WAYS      = 4,
  parameter int PT0_MSB   = 25,
  parameter int PAR1_BIT  = 11,
  parameter int PAR0_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HI_W-1:0]   in_tag_hi,
  input  logic [LO_W-1:0]   in_tag_lo,
  input  logic [IDX_W-1:0]  in_index,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_state_err,
  output logic              out_addr_err,
  output logic [CODE_W-1:0] out_state,
  output logic [PA_W-1:0]   out_paddr,
  output logic [2*WAYS-1:0] out_lru
);

  localparam int WW       = $clog2(WAYS);
  localparam int LRU_W    = WAYS * WW;
  localparam int PTAG_LSB = IDX_W;
  localparam int PTAG_MSB = PA_W - 1;
  localparam int PT1_LSB  = PT0_MSB + 1;

  logic [STATE_W-1:0] raw_state;
  cstate_e            code_c;
  logic               legal_c;
  logic               mis1_c;
  logic               mis0_c;
  logic [LRU_W-1:0]   lru_c;
  logic [PA_W-1:0]    pa_c;
  logic               take;

  assign raw_state = in_tag_hi[STATE_LSB +: STATE_W];

  dctag_state_decode u_dec (
    .raw   (raw_state),
    .code  (code_c),
    .legal (legal_c)
  );

  dctag_span_parity #(.W(LO_W), .MSB(PTAG_MSB), .LSB(PT1_LSB)) u_par_hi (
    .word     (in_tag_lo),
    .stored   (in_tag_lo[PAR1_BIT]),
    .mismatch (mis1_c)
  );

  dctag_span_parity #(.W(LO_W), .MSB(PT0_MSB), .LSB(PTAG_LSB)) u_par_lo (
    .word     (in_tag_lo),
    .stored   (in_tag_lo[PAR0_BIT]),
    .mismatch (mis0_c)
  );

  dctag_lru_unpack #(.WAYS(WAYS), .WW(WW)) u_lru (
    .field (in_tag_hi[LRU_LSB +: LRU_W]),
    .order (lru_c)
  );

  assign pa_c     = {in_tag_lo[PTAG_MSB:PTAG_LSB], in_index};
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_state_err <= 1'b0;
      out_addr_err  <= 1'b0;
      out_state     <= '0;
      out_paddr     <= '0;
      out_lru       <= '0;
    end else if (take) begin
      out_state_err <= !legal_c;
      out_addr_err  <= legal_c && (mis1_c || mis0_c);
      out_state     <= code_c;
      out_paddr     <= pa_c;
      out_lru       <= lru_c;
    end
  end

endmodule

// File: rtl/dctag_check_sva.sv
module dctag_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_state_err,
  input logic        out_addr_err,
  input logic [2:0]  out_state,
  input logic [39:0] out_paddr,
  input logic [7:0]  out_lru
);

  a_r2_illegal_masks_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_state_err) |-> !out_addr_err);

  a_r2_code_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_state == 3'd7) == out_state_err));

  a_r1_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_state != 3'd6));

  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state) && $stable(out_paddr)
                                   && $stable(out_lru) && $stable(out_state_err)
                                   && $stable(out_addr_err)));

  a_r7_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind dctag_check dctag_check_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_state_err (out_state_err),
  .out_addr_err  (out_addr_err),
  .out_state     (out_state),
  .out_paddr     (out_paddr),
  .out_lru       (out_lru)
);

// File: tb/dctag_check_bench.sv
module dctag_check_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        se;
    logic        ae;
    logic [2:0]  st;
    logic [39:0] pa;
    logic [7:0]  lru;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_tag_hi = '0;
  logic [63:0] in_tag_lo = '0;
  logic [12:0] in_index = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_state_err;
  logic        out_addr_err;
  logic [2:0]  out_state;
  logic [39:0] out_paddr;
  logic [7:0]  out_lru;

  int    n_checks = 0;
  int    n_fail   = 0;
  exp_t  q_exp[$];
  string q_tag[$];
  logic [63:0] rs = 64'h9E3779B97F4A7C15;
  logic [15:0] bp = 16'hACE1;
  bit    bp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dctag_check u_dctag_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_tag_hi     (in_tag_hi),
    .in_tag_lo     (in_tag_lo),
    .in_index      (in_index),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_state_err (out_state_err),
    .out_addr_err  (out_addr_err),
    .out_state     (out_state),
    .out_paddr     (out_paddr),
    .out_lru       (out_lru)
  );

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic exp_t model(logic [31:0] hi, logic [63:0] lo, logic [12:0] idx);
    exp_t e;
    logic legal;
    legal = 1'b1;
    case (hi[29:25])
      5'h00: e.st = 3'd0;
      5'h0F: e.st = 3'd1;
      5'h13: e.st = 3'd2;
      5'h19: e.st = 3'd3;
      5'h16: e.st = 3'd4;
      5'h1C: e.st = 3'd5;
      default: begin e.st = 3'd7; legal = 1'b0; end
    endcase
    e.se  = !legal;
    e.ae  = legal && ((lo[11] != ^lo[39:26]) || (lo[10] != ^lo[25:13]));
    e.pa  = {lo[39:13], idx};
    e.lru = hi[21:14];
    return e;
  endfunction

  function automatic logic [63:0] good_par(logic [63:0] lo);
    logic [63:0] r;
    r = lo;
    r[11] = ^lo[39:26];
    r[10] = ^lo[25:13];
    return r;
  endfunction

  function automatic logic [31:0] mk_hi(logic [4:0] st, logic [7:0] lru, logic [31:0] noise);
    logic [31:0] h;
    h = noise;
    h[29:25] = st;
    h[21:14] = lru;
    return h;
  endfunction

  task automatic send(input logic [31:0] hi, input logic [63:0] lo,
                      input logic [12:0] idx, input string tag);
    q_exp.push_back(model(hi, lo, idx));
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
    in_valid  = 1'b1;
    in_tag_hi = hi;
    in_tag_lo = lo;
    in_index  = idx;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    in_tag_hi = rnd()[31:0];
    in_tag_lo = rnd();
  endtask

  // consumer: pseudo-random back-pressure, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      bp = {bp[14:0], bp[15] ^ bp[13] ^ bp[12] ^ bp[10]};
      out_ready = bp_on ? (bp[0] | bp[3]) : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_checks++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected result: actual state=%0d expected none", out_state);
      end else begin
        exp_t  e;
        string t;
        exp_t  a;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = '{se: out_state_err, ae: out_addr_err, st: out_state, pa: out_paddr, lru: out_lru};
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s actual se=%0b ae=%0b st=%0d pa=%h lru=%h expected se=%0b ae=%0b st=%0d pa=%h lru=%h",
                   t, a.se, a.ae, a.st, a.pa, a.lru, e.se, e.ae, e.st, e.pa, e.lru);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] legal_tbl [6];
    logic [63:0] lo;
    legal_tbl = '{5'h00, 5'h0F, 5'h13, 5'h19, 5'h16, 5'h1C};

    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 reset: actual out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end

    // R1: every legal encoding, good parity
    for (int k = 0; k < 6; k++) begin
      lo = good_par(64'h0000_00A5_5A3C_E000 ^ (64'(k) << 20));
      send(mk_hi(legal_tbl[k], 8'b11_10_01_00, 32'h0), lo, 13'h1ABC, "R1");
    end
    // R2: illegal states with good and corrupted parity
    send(mk_hi(5'h01, 8'h1B, 32'h0), good_par(64'hFF_1234_5000), 13'h0001, "R2");
    send(mk_hi(5'h1F, 8'h1B, 32'h0), good_par(64'hFF_1234_5000) ^ 64'hC00, 13'h0002, "R2");
    send(mk_hi(5'h10, 8'h00, 32'h0), good_par(64'h00_0000_2000) ^ 64'h800, 13'h1FFF, "R2");
    // R3: upper parity bit wrong alone
    send(mk_hi(5'h0F, 8'hE4, 32'h0), good_par(64'h80_0000_0000) ^ 64'h800, 13'h0000, "R3");
    // R4: lower parity bit wrong alone, both wrong, both good
    send(mk_hi(5'h19, 8'h4E, 32'h0), good_par(64'h00_0000_2000) ^ 64'h400, 13'h0AAA, "R4");
    send(mk_hi(5'h1C, 8'h4E, 32'h0), good_par(64'h5A_5A5A_A000) ^ 64'hC00, 13'h1555, "R4");
    send(mk_hi(5'h13, 8'h4E, 32'h0), good_par(64'h5A_5A5A_A000), 13'h1555, "R4");
    // R5: address extremes
    send(mk_hi(5'h16, 8'h00, 32'h0), good_par(64'hFF_FFFF_E000), 13'h1FFF, "R5");
    send(mk_hi(5'h16, 8'h00, 32'h0), good_par(64'h0), 13'h0000, "R5");
    // R6: distinct way orders
    send(mk_hi(5'h00, 8'b00_01_10_11, 32'h0), good_par(64'h0), 13'h0010, "R6");
    send(mk_hi(5'h00, 8'b10_00_11_01, 32'h0), good_par(64'h0), 13'h0020, "R6");
    // R9: noise in ignored bits
    send(mk_hi(5'h0F, 8'h93, 32'hC1F0_3FFF), good_par(64'hFFFF_FF00_0000_03FF), 13'h0F0F, "R9");
    send(mk_hi(5'h05, 8'h93, 32'hFFFF_FFFF), 64'hFFFF_FFFF_FFFF_FFFF, 13'h0F0F, "R9");

    // R7: random traffic under back-pressure
    bp_on = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r1;
      logic [63:0] r2;
      logic [4:0]  st;
      r1 = rnd();
      r2 = rnd();
      st = (r1[2:0] < 3'd6) ? legal_tbl[r1[2:0]] : r1[7:3];
      lo = r1[8] ? good_par(r2) : r2;
      send(mk_hi(st, r1[23:16], r1[63:32]), lo, r1[36:24], "R7");
    end
    bp_on = 1'b0;

    wait (q_exp.size() == 0);
    repeat (4) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule